// File: doc/BRIEF.md
# DDR SDRAM power-up and refresh sequencer

This block brings a DDR SDRAM out of power-up and then keeps it refreshed. After a synchronous reset it holds clock enable low for a stabilisation period, raises it, and issues the required sequence: precharge-all, extended mode load with the DLL enabled, base mode load with DLL reset, a second precharge-all, two auto-refreshes, and a final base mode load without DLL reset. Every command is followed by NOP cycles that cover the matching memory timing (precharge, mode-load or refresh recovery). When the last wait expires it raises `init_done` and gives the command bus to the user command executor.

In normal operation an interval counter adds one owed refresh each period. While any refresh is owed, the block raises `user_hold` so that the executor stops issuing user commands. Once the executor reports `exec_idle`, the sequencer takes the bus, closes every bank with precharge-all, issues auto-refresh, waits out the refresh recovery time and hands the bus back. Owed refreshes accumulate up to a limit and are served back to back. The sequencer drives the command pins only while `bus_own` is high. Otherwise it drives a NOP with zero address so that the executor's bus can be merged with it.

Top module: `ddr_initref`

## Requirements
- R1: From reset release, `cke` is low for exactly T_STAB cycles with NOP on the bus. It is then high for one NOP cycle before the first command, and stays high until the next reset.
- R2: Commands are encoded on {ras_n,cas_n,we_n} as NOP 111, precharge 010, mode load 000 and auto-refresh 001. The init commands come in this order: precharge, extended mode load, mode load with DLL reset, precharge, refresh, refresh, mode load.
- R3: Each command is separated from the next by exactly T_RP cycles after a precharge, T_MRD cycles after a mode load and T_RFC cycles after a refresh, with NOP in every cycle between.
- R4: `init_done` is low from reset through the whole sequence. It rises exactly T_MRD cycles after the final mode load and stays high until reset.
- R5: A precharge drives addr[10]=1 and ba=00. The extended mode load uses ba=01 with all address bits zero. The base mode load uses ba=00, with burst length in addr[2:0] (2→001, 4→010, 8→011), addr[3]=0, and CAS latency in addr[6:4] (2→010, 2.5→110, 3→011). addr[8]=1 only on the first base load, and all other bits are zero.
- R6: With the executor idle, a refresh precharge is issued every T_REFI cycles. The first one is issued T_REFI+1 cycles after `init_done` rises.
- R7: A refresh consists of precharge-all, then auto-refresh T_RP cycles later. The bus is released (`bus_own` low) exactly T_RFC cycles after the auto-refresh.
- R8: While the executor is not idle in normal operation, the sequencer issues nothing and keeps `bus_own` low. `user_hold` is high from the cycle after an interval elapses until the owed refresh is served.
- R9: Refreshes owed while the executor is busy are kept, up to OWED_MAX of them. They are issued back to back once `exec_idle` is seen, one precharge every T_RP+T_RFC+1 cycles, the first in the cycle after `exec_idle` is sampled high.
- R10: Whenever `bus_own` is low, the command pins show NOP with ba and addr zero.
- R11: A reset at any time restarts the sequence: after the reset edge `init_done` and `cke` are low and the bus is owned and idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_idle | input | 1 | User command executor has no command in flight |
| init_done | output | 1 | Power-up sequence finished |
| user_hold | output | 1 | User commands must not be issued |
| bus_own | output | 1 | Sequencer currently drives the command bus |
| cke | output | 1 | Memory clock enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Memory address / mode word |

## Verification
The bench logs every command cycle by cycle after each reset. It compares the logged stream against a schedule built arithmetically from the timing parameters, so a wait that is off by one cycle, or a swapped pair of mode loads, shows up as a shifted or mismatched event. A backlog test holds the executor busy across two intervals and across seven intervals. A sequencer that drops owed refreshes would serve only one, and one that does not saturate would serve seven. Extra instances with other CAS latency and burst length values catch a wrong mode-word code, in particular the 2.5 latency code. A refresh that started while the executor was busy would show up as commands, or as a raised `bus_own`, inside the hold window.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

   typedef enum logic [3:0] {
      ST_STAB, ST_CKEUP, ST_PRE0, ST_EMR, ST_MRR, ST_PRE1,
      ST_AR0, ST_AR1, ST_MRF, ST_WAIT, ST_RUN, ST_RPRE, ST_RREF
   } seq_state_t;

   typedef logic [2:0] cmd_t;   // {ras_n, cas_n, we_n}

   localparam cmd_t CMD_NOP = 3'b111;
   localparam cmd_t CMD_PRE = 3'b010;
   localparam cmd_t CMD_LMR = 3'b000;
   localparam cmd_t CMD_REF = 3'b001;

   localparam int A10_BIT    = 10;  // all-banks flag on precharge
   localparam int DLLRST_BIT = 8;   // DLL reset in base mode word

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/ddr_step_timer.sv
module ddr_step_timer #(
   parameter int CW      = 4,
   parameter int RST_VAL = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CW'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == CW'(1));

endmodule

// File: rtl/ddr_refi_timer.sv
module ddr_refi_timer #(
   parameter int T_REFI   = 100,
   parameter int OWED_MAX = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic served,
   output logic owed_any
);

   localparam int IW = $clog2(T_REFI);
   localparam int OW = $clog2(OWED_MAX + 1);

   logic [IW-1:0] ivl_q;
   logic [OW-1:0] owed_q;
   logic          tick;

   assign tick = en && (ivl_q == IW'(T_REFI - 1));

   always_ff @(posedge clk) begin
      if (rst || !en)
         ivl_q <= '0;
      else if (tick)
         ivl_q <= '0;
      else
         ivl_q <= ivl_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         owed_q <= '0;
      else begin
         unique case ({tick, served})
            2'b10:   if (owed_q < OW'(OWED_MAX)) owed_q <= owed_q + 1'b1;
            2'b01:   if (owed_q != '0) owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   assign owed_any = (owed_q != '0);

endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word import ddr_seq_pkg::*; #(
   parameter int ADDR_W    = 13,
   parameter int BURST_LEN = 4,
   parameter int CL_X2     = 5
) (
   output logic [ADDR_W-1:0] mr_dllrst,
   output logic [ADDR_W-1:0] mr_run
);

   logic [2:0] cl_code;
   logic [2:0] bl_code;

   generate
      if (CL_X2 == 4) begin : g_cl20
         assign cl_code = 3'b010;
      end else if (CL_X2 == 5) begin : g_cl25
         assign cl_code = 3'b110;
      end else begin : g_cl30
         assign cl_code = 3'b011;
      end

      if (BURST_LEN == 2) begin : g_bl2
         assign bl_code = 3'b001;
      end else if (BURST_LEN == 4) begin : g_bl4
         assign bl_code = 3'b010;
      end else begin : g_bl8
         assign bl_code = 3'b011;
      end
   endgenerate

   assign mr_run    = ADDR_W'({cl_code, 1'b0, bl_code});
   assign mr_dllrst = mr_run | (ADDR_W'(1) << DLLRST_BIT);

endmodule

// File: rtl/ddr_initref.sv
module ddr_initref import ddr_seq_pkg::*; #(
   parameter int ADDR_W    = 13,
   parameter int BURST_LEN = 4,
   parameter int CL_X2     = 5,
   parameter int T_STAB    = 6,
   parameter int T_RP      = 3,
   parameter int T_MRD     = 2,
   parameter int T_RFC     = 8,
   parameter int T_REFI    = 100,
   parameter int OWED_MAX  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exec_idle,
   output logic              init_done,
   output logic              user_hold,
   output logic              bus_own,
   output logic              cke,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr
);

   localparam int T_MAX = max4(T_STAB, T_RP, T_MRD, T_RFC);
   localparam int CW    = $clog2(T_MAX + 1);

   initial begin : elab_chk
      if (ADDR_W <= A10_BIT)              $error("ADDR_W must exceed 10");
      if (CL_X2 < 4 || CL_X2 > 6)         $error("CL_X2 must be 4, 5 or 6");
      if (!(BURST_LEN inside {2, 4, 8}))  $error("BURST_LEN must be 2, 4 or 8");
      if (T_STAB < 1)                     $error("T_STAB must be at least 1");
      if (T_RP < 2 || T_MRD < 2 || T_RFC < 2) $error("waits must be at least 2");
      if (OWED_MAX < 1)                   $error("OWED_MAX must be at least 1");
      if (T_REFI <= T_RP + T_RFC + 2)     $error("T_REFI too short");
   end

   seq_state_t        state_q, nxt;
   seq_state_t        ret_q, ret_n;
   logic              t_load, t_exp;
   logic [CW-1:0]     t_val;
   cmd_t              cmd;
   logic [1:0]        ba_c;
   logic [ADDR_W-1:0] addr_c;
   logic [ADDR_W-1:0] mr_dllrst, mr_run;
   logic              owed_any;

   ddr_step_timer #(.CW(CW), .RST_VAL(T_STAB)) u_step (
      .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expire(t_exp)
   );

   ddr_refi_timer #(.T_REFI(T_REFI), .OWED_MAX(OWED_MAX)) u_refi (
      .clk(clk), .rst(rst), .en(init_done),
      .served(state_q == ST_RREF), .owed_any(owed_any)
   );

   ddr_mode_word #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .CL_X2(CL_X2)) u_mode (
      .mr_dllrst(mr_dllrst), .mr_run(mr_run)
   );

   always_comb begin
      nxt    = state_q;
      ret_n  = ret_q;
      t_load = 1'b0;
      t_val  = '0;
      cmd    = CMD_NOP;
      ba_c   = 2'b00;
      addr_c = '0;
      unique case (state_q)
         ST_STAB:  if (t_exp) nxt = ST_CKEUP;
         ST_CKEUP: nxt = ST_PRE0;
         ST_PRE0, ST_PRE1, ST_RPRE: begin
            cmd             = CMD_PRE;
            addr_c[A10_BIT] = 1'b1;
            nxt             = ST_WAIT;
            t_load          = 1'b1;
            t_val           = CW'(T_RP - 1);
            if (state_q == ST_PRE0)      ret_n = ST_EMR;
            else if (state_q == ST_PRE1) ret_n = ST_AR0;
            else                         ret_n = ST_RREF;
         end
         ST_EMR: begin
            cmd    = CMD_LMR;
            ba_c   = 2'b01;
            nxt    = ST_WAIT;
            t_load = 1'b1;
            t_val  = CW'(T_MRD - 1);
            ret_n  = ST_MRR;
         end
         ST_MRR, ST_MRF: begin
            cmd    = CMD_LMR;
            addr_c = (state_q == ST_MRR) ? mr_dllrst : mr_run;
            nxt    = ST_WAIT;
            t_load = 1'b1;
            t_val  = CW'(T_MRD - 1);
            ret_n  = (state_q == ST_MRR) ? ST_PRE1 : ST_RUN;
         end
         ST_AR0, ST_AR1, ST_RREF: begin
            cmd    = CMD_REF;
            nxt    = ST_WAIT;
            t_load = 1'b1;
            t_val  = CW'(T_RFC - 1);
            if (state_q == ST_AR0)      ret_n = ST_AR1;
            else if (state_q == ST_AR1) ret_n = ST_MRF;
            else                        ret_n = ST_RUN;
         end
         ST_WAIT: if (t_exp) nxt = ret_q;
         ST_RUN:  if (owed_any && exec_idle) nxt = ST_RPRE;
         default: nxt = ST_STAB;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_STAB;
         ret_q     <= ST_STAB;
         init_done <= 1'b0;
      end else begin
         state_q <= nxt;
         ret_q   <= ret_n;
         if (nxt == ST_RUN) init_done <= 1'b1;
      end
   end

   assign bus_own   = (state_q != ST_RUN);
   assign cke       = (state_q != ST_STAB);
   assign user_hold = !init_done || owed_any || bus_own;
   assign ras_n     = cmd[2];
   assign cas_n     = cmd[1];
   assign we_n      = cmd[0];
   assign ba        = ba_c;
   assign addr      = addr_c;

endmodule

// File: rtl/ddr_initref_chk.sv
module ddr_initref_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst,
   input logic              exec_idle,
   input logic              init_done,
   input logic              user_hold,
   input logic              bus_own,
   input logic              cke,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr
);

   logic [2:0] c;
   assign c = {ras_n, cas_n, we_n};

   p_free_bus_nop_r10: assert property (@(posedge clk) disable iff (rst)
      !bus_own |-> (c == 3'b111 && ba == 2'b00 && addr == '0));

   p_cke_low_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !cke |-> c == 3'b111);

   p_cke_stays_r1: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   p_done_needs_cke_r4: assert property (@(posedge clk) disable iff (rst)
      init_done |-> cke);

   p_cmd_then_nop_r3: assert property (@(posedge clk) disable iff (rst)
      (c != 3'b111) |=> (c == 3'b111));

   p_prea_all_r5: assert property (@(posedge clk) disable iff (rst)
      (c == 3'b010) |-> (addr[10] && ba == 2'b00));

   p_emr_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (c == 3'b000 && ba == 2'b01) |-> addr == '0);

   p_own_holds_user_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_own && init_done) |-> user_hold);

   p_take_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
      ($rose(bus_own) && init_done) |-> $past(exec_idle));

   p_reset_clears_r11: assert property (@(posedge clk)
      rst |=> (!init_done && !cke && bus_own));

endmodule

bind ddr_initref ddr_initref_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .exec_idle(exec_idle), .init_done(init_done),
   .user_hold(user_hold), .bus_own(bus_own), .cke(cke), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
);

// File: tb/ddr_initref_tb_top.sv
`timescale 1ns/1ps
module ddr_initref_tb_top;

   localparam int AW = 13, TS = 6, TRP = 3, TMRD = 2, TRFC = 8, TREFI = 100, OWM = 3;
   localparam logic [2:0] K_NOP = 3'b111, K_PRE = 3'b010, K_LMR = 3'b000, K_REF = 3'b001;

   logic clk = 1'b0, rst = 1'b1, idle = 1'b1;
   logic done, hold, own, cke, ras, cas, we;
   logic [1:0] ba;
   logic [AW-1:0] addr;
   logic b_done, b_hold, b_own, b_cke, b_ras, b_cas, b_we;
   logic [1:0] b_ba;
   logic [AW-1:0] b_addr;
   logic c_done, c_hold, c_own, c_cke, c_ras, c_cas, c_we;
   logic [1:0] c_ba;
   logic [AW-1:0] c_addr;

   ddr_initref #(.ADDR_W(AW), .BURST_LEN(4), .CL_X2(5), .T_STAB(TS), .T_RP(TRP),
      .T_MRD(TMRD), .T_RFC(TRFC), .T_REFI(TREFI), .OWED_MAX(OWM)) dut_i (
      .clk(clk), .rst(rst), .exec_idle(idle), .init_done(done), .user_hold(hold),
      .bus_own(own), .cke(cke), .ras_n(ras), .cas_n(cas), .we_n(we), .ba(ba), .addr(addr));

   ddr_initref #(.ADDR_W(AW), .BURST_LEN(8), .CL_X2(6), .T_STAB(TS), .T_RP(TRP),
      .T_MRD(TMRD), .T_RFC(TRFC), .T_REFI(TREFI), .OWED_MAX(OWM)) dut_b (
      .clk(clk), .rst(rst), .exec_idle(idle), .init_done(b_done), .user_hold(b_hold),
      .bus_own(b_own), .cke(b_cke), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr));

   ddr_initref #(.ADDR_W(AW), .BURST_LEN(2), .CL_X2(4), .T_STAB(TS), .T_RP(TRP),
      .T_MRD(TMRD), .T_RFC(TRFC), .T_REFI(TREFI), .OWED_MAX(OWM)) dut_c (
      .clk(clk), .rst(rst), .exec_idle(idle), .init_done(c_done), .user_hold(c_hold),
      .bus_own(c_own), .cke(c_cke), .ras_n(c_ras), .cas_n(c_cas), .we_n(c_we), .ba(c_ba), .addr(c_addr));

   always #2.5 clk = ~clk;

   int cyc = 0;
   int n_tests = 0, n_fail = 0;
   bit fin = 1'b0;

   logic [2:0]    cmd_log  [0:1023];
   logic [1:0]    ba_log   [0:1023];
   logic [AW-1:0] addr_log [0:1023];
   logic          own_log  [0:1023];
   logic          done_log [0:1023];
   logic          cke_log  [0:1023];
   logic          hold_log [0:1023];
   logic [AW-1:0] mrb [0:1];
   logic [AW-1:0] mrc [0:1];
   int nb = 0, nc = 0;

   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; nb = 0; nc = 0;
      end else begin
         cyc = cyc + 1;
         if (cyc < 1024) begin
            cmd_log[cyc]  = {ras, cas, we};
            ba_log[cyc]   = ba;
            addr_log[cyc] = addr;
            own_log[cyc]  = own;
            done_log[cyc] = done;
            cke_log[cyc]  = cke;
            hold_log[cyc] = hold;
         end
         if ({b_ras, b_cas, b_we} == K_LMR && b_ba == 2'b00 && nb < 2) begin
            mrb[nb] = b_addr; nb = nb + 1;
         end
         if ({c_ras, c_cas, c_we} == K_LMR && c_ba == 2'b00 && nc < 2) begin
            mrc[nc] = c_addr; nc = nc + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R5 mode word: addr[6:4] CAS code, addr[2:0] burst code
   function automatic int mr_word(input int clx2, input int bl);
      int clc, blc;
      clc = (clx2 == 4) ? 2 : (clx2 == 5) ? 6 : 3;
      blc = (bl == 2) ? 1 : (bl == 4) ? 2 : 3;
      return clc * 16 + blc;
   endfunction

   int         ex_c [0:31];
   logic [2:0] ex_k [0:31];
   int         ex_b [0:31];
   int         ex_a [0:31];
   string      ex_r [0:31];
   int         nex;

   task automatic add_ev(input int c, input logic [2:0] k, input int b, input int a, input string r);
      ex_c[nex] = c; ex_k[nex] = k; ex_b[nex] = b; ex_a[nex] = a; ex_r[nex] = r;
      nex++;
   endtask

   task automatic build_init(output int d);
      int t, mw;
      mw = mr_word(5, 4);
      nex = 0;
      t = TS + 2;     add_ev(t, K_PRE, 0, 1024, "R2");
      t = t + TRP;    add_ev(t, K_LMR, 1, 0, "R2");
      t = t + TMRD;   add_ev(t, K_LMR, 0, mw + 256, "R5");
      t = t + TMRD;   add_ev(t, K_PRE, 0, 1024, "R3");
      t = t + TRP;    add_ev(t, K_REF, 0, 0, "R3");
      t = t + TRFC;   add_ev(t, K_REF, 0, 0, "R3");
      t = t + TRFC;   add_ev(t, K_LMR, 0, mw, "R5");
      d = t + TMRD;
   endtask

   task automatic add_ref(input int p, input string r);
      add_ev(p, K_PRE, 0, 1024, r);
      add_ev(p + TRP, K_REF, 0, 0, "R7");
   endtask

   task automatic compare(input int upto);
      int i;
      i = 0;
      for (int c = 1; c <= upto; c++) begin
         if (cmd_log[c] != K_NOP) begin
            if (i < nex) begin
               chk(c == ex_c[i], ex_r[i], "command cycle", c, ex_c[i]);
               chk(cmd_log[c] == ex_k[i] && int'(ba_log[c]) == ex_b[i] && int'(addr_log[c]) == ex_a[i],
                   ex_r[i], "command kind/ba/addr",
                   longint'({cmd_log[c], ba_log[c], addr_log[c]}),
                   longint'({ex_k[i], ex_b[i][1:0], ex_a[i][AW-1:0]}));
            end
            i++;
         end
      end
      chk(i == nex, "R2", "command count", i, nex);
   endtask

   task automatic free_bus_scan(input int upto);
      int bad;
      bad = 0;
      for (int c = 1; c <= upto; c++)
         if (!own_log[c] && (cmd_log[c] != K_NOP || ba_log[c] != 0 || addr_log[c] != 0)) bad++;
      chk(bad == 0, "R10", "non-idle pins while bus free", bad, 0);
   endtask

   task automatic wait_cyc(input int n);
      do begin
         @(negedge clk); #1;
      end while (cyc < n);
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk);
      @(negedge clk); #1;
      chk(!done && !cke && own && {ras, cas, we} == K_NOP, "R11", "state after reset edge",
          longint'({done, cke, own, ras, cas, we}), longint'({3'b001, K_NOP}));
      @(posedge clk); #1 rst = 1'b0;
   endtask

   task automatic init_checks(input int d, input int upto);
      int bad;
      bad = 0;
      for (int c = 1; c <= TS; c++) if (cke_log[c]) bad++;
      chk(bad == 0, "R1", "cke high during stabilisation", bad, 0);
      chk(cke_log[TS + 1] && cmd_log[TS + 1] == K_NOP, "R1", "cke-up NOP cycle",
          longint'({cke_log[TS + 1], cmd_log[TS + 1]}), longint'({1'b1, K_NOP}));
      bad = 0;
      for (int c = TS + 1; c <= upto; c++) if (!cke_log[c]) bad++;
      chk(bad == 0, "R1", "cke dropped after rise", bad, 0);
      bad = 0;
      for (int c = 1; c < d; c++) if (done_log[c] || !own_log[c]) bad++;
      chk(bad == 0, "R4", "done high or bus free during init", bad, 0);
      bad = 0;
      for (int c = d; c <= upto; c++) if (!done_log[c]) bad++;
      chk(bad == 0, "R4", "init_done not high from expected cycle", bad, 0);
   endtask

   int d, rr, p, bad;

   initial begin
      // phase 1: executor always idle
      idle = 1'b1;
      do_reset();
      wait_cyc(260);
      build_init(d);
      add_ref(d + TREFI + 1, "R6");
      add_ref(d + 2 * TREFI + 1, "R6");
      compare(259);
      init_checks(d, 259);
      p = d + TREFI + 1 + TRP + TRFC;
      chk(own_log[p - 1] && !own_log[p], "R7", "bus release after refresh",
          longint'({own_log[p - 1], own_log[p]}), 2);
      chk(!hold_log[d + TREFI - 1] && hold_log[d + TREFI], "R8", "user_hold on owed refresh",
          longint'({hold_log[d + TREFI - 1], hold_log[d + TREFI]}), 1);
      free_bus_scan(259);
      chk(nb == 2 && mrb[0] == AW'(mr_word(6, 8) + 256), "R5", "CL3 BL8 DLL-reset word",
          mrb[0], mr_word(6, 8) + 256);
      chk(mrb[1] == AW'(mr_word(6, 8)), "R5", "CL3 BL8 run word", mrb[1], mr_word(6, 8));
      chk(nc == 2 && mrc[0] == AW'(mr_word(4, 2) + 256), "R5", "CL2 BL2 DLL-reset word",
          mrc[0], mr_word(4, 2) + 256);
      chk(mrc[1] == AW'(mr_word(4, 2)), "R5", "CL2 BL2 run word", mrc[1], mr_word(4, 2));

      // phase 2: busy across two intervals
      idle = 1'b0;
      do_reset();
      rr = 300;
      wait_cyc(rr);
      idle = 1'b1;
      wait_cyc(345);
      build_init(d);
      add_ref(rr + 1, "R9");
      add_ref(rr + 1 + TRP + TRFC + 1, "R9");
      add_ref(d + 3 * TREFI + 1, "R6");
      compare(345);
      init_checks(d, 345);
      bad = 0;
      for (int c = d; c <= rr; c++) if (own_log[c] || cmd_log[c] != K_NOP) bad++;
      chk(bad == 0, "R8", "sequencer active while executor busy", bad, 0);
      bad = 0;
      for (int c = d + TREFI; c <= rr; c++) if (!hold_log[c]) bad++;
      chk(bad == 0, "R8", "user_hold dropped with refresh owed", bad, 0);
      free_bus_scan(345);

      // phase 3: busy across seven intervals, backlog saturates
      idle = 1'b0;
      do_reset();
      rr = 760;
      wait_cyc(rr);
      idle = 1'b1;
      wait_cyc(850);
      build_init(d);
      for (int k = 0; k < OWM; k++) add_ref(rr + 1 + k * (TRP + TRFC + 1), "R9");
      add_ref(d + 8 * TREFI + 1, "R6");
      compare(850);
      init_checks(d, 850);
      free_bus_scan(850);

      fin = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!fin) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule